// File: doc/BRIEF.md
# Bit-Sliced Configurable ALU

This block is a small arithmetic and logic unit assembled from a parameterised number of identical one-bit cells. Every cell carries its own 2-to-4 operation decoder, a logic section (AND, OR, complement of B) and a full adder. The decoded lines steer exactly one of the four candidate bits to the cell output. The carry ripples from the least significant cell upward. Only the most significant cell's carry leaves the block, and it is exported only during the sum operation.

Three conditioning controls sit in front of the operation. Each operand has an enable that forces it to zero when low. A separate control then complements operand A. Together with the four operations, these produce pass-through of either operand, the complement of A, the constants zero and all-ones, and increment via the carry input, all without extra datapath.

The word-level wrapper derives a negative flag and a zero flag from the result. A parameter selects whether the flags are registered, appearing one clock after the operands, or follow the result combinationally. Result and carry-out are always combinational.

Top module: `bsalu_top`

## Requirements
- R1: Operation select encoding is 00 = bitwise AND and 01 = bitwise OR of the conditioned operands.
- R2: Operation select 10 gives the bitwise complement of the conditioned B operand.
- R3: Operation select 11 gives the low WIDTH bits of conditioned A + conditioned B + carry_in, and carry_out equals bit WIDTH of that sum.
- R4: For operation selects 00, 01 and 10, carry_out is 0 whatever the operands and carry_in.
- R5: When en_a is 0, operand A is taken as zero. When en_b is 0, operand B is taken as zero. With OR and one enable low, the result is the other operand unchanged.
- R6: When inv_a is 1, the conditioned A is the complement of (en_a ? op_a : 0). So en_a = 0 with inv_a = 1 yields all-ones, and OR with en_b = 0 yields NOT A.
- R7: flag_neg equals the most significant result bit, i.e. the result's sign as a two's complement number.
- R8: flag_zero is 1 exactly when every result bit is 0.
- R9: With REG_FLAGS = 1, the flags show the values for the operands present at the previous rising clock edge, and both flags are 0 while rst_n is low.
- R10: With REG_FLAGS = 0, the flags follow the current result with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered flag option |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| fn_sel | input | 2 | Operation select (00 AND, 01 OR, 10 NOT B, 11 SUM) |
| en_a | input | 1 | Operand A enable; 0 forces A to zero |
| en_b | input | 1 | Operand B enable; 0 forces B to zero |
| inv_a | input | 1 | Complement conditioned A |
| carry_in | input | 1 | Carry into the least significant cell |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry out of the top cell, zero outside SUM |
| flag_neg | output | 1 | Result sign bit |
| flag_zero | output | 1 | Result is all zeros |

## Verification
The bench builds one copy with WIDTH = 4 and registered flags. At that width every combination of both operands, all four operations, both enables, the inversion control and the carry input fits in about sixteen thousand vectors. This covers every carry-ripple pattern and every flag edge, including the constant results. A second copy with WIDTH = 8 and combinational flags receives directed vectors: operand pass-through, NOT A, all-ones, increment, and the full-width wrap from all-ones to zero.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

    typedef enum logic [1:0] {
        OP_AND  = 2'b00,
        OP_OR   = 2'b01,
        OP_NOTB = 2'b10,
        OP_SUM  = 2'b11
    } alu_op_e;

    localparam int NUM_OPS = 4;

    typedef struct packed {
        logic neg;
        logic zero;
    } alu_flags_t;

endpackage

// File: rtl/bsalu_op_decode.sv
module bsalu_op_decode
    import bsalu_pkg::*;
(
    input  logic [1:0]         sel,
    output logic [NUM_OPS-1:0] line
);
    // One-hot line per operation code
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_line
        assign line[i] = (sel == 2'(i));
    end
endmodule

// File: rtl/bsalu_slice.sv
module bsalu_slice
    import bsalu_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       en_a,
    input  logic       en_b,
    input  logic       inv_a,
    input  logic [1:0] op_sel,
    input  logic       carry_i,
    output logic       res_bit,
    output logic       carry_o
);
    logic               a_in;
    logic               b_in;
    logic [NUM_OPS-1:0] dec;
    logic [NUM_OPS-1:0] cand;

    bsalu_op_decode u_dec (
        .sel  (op_sel),
        .line (dec)
    );

    always_comb begin
        // enable first, then optional complement
        a_in = (a_bit & en_a) ^ inv_a;
        b_in = b_bit & en_b;
        cand[OP_AND]  = a_in & b_in;
        cand[OP_OR]   = a_in | b_in;
        cand[OP_NOTB] = ~b_in;
        cand[OP_SUM]  = a_in ^ b_in ^ carry_i;
        carry_o = (a_in & b_in) | (carry_i & (a_in ^ b_in));
        // gate each candidate by its decoded line, merge with OR
        res_bit = |(dec & cand);
    end
endmodule

// File: rtl/bsalu_flags.sv
module bsalu_flags
    import bsalu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] word,
    output alu_flags_t       flags
);
    always_comb begin
        flags.neg  = word[WIDTH-1];
        flags.zero = ~(|word);
    end
endmodule

// File: rtl/bsalu_top.sv
module bsalu_top
    import bsalu_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter bit REG_FLAGS = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [1:0]       fn_sel,
    input  logic             en_a,
    input  logic             en_b,
    input  logic             inv_a,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             flag_neg,
    output logic             flag_zero
);
    localparam int CHAIN_LEN = WIDTH + 1;

    logic [CHAIN_LEN-1:0] chain;
    logic [WIDTH-1:0]     res_w;
    alu_flags_t           flags_d;
    alu_flags_t           flags_q;

    assign chain[0] = carry_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        bsalu_slice u_slice (
            .a_bit   (op_a[i]),
            .b_bit   (op_b[i]),
            .en_a    (en_a),
            .en_b    (en_b),
            .inv_a   (inv_a),
            .op_sel  (fn_sel),
            .carry_i (chain[i]),
            .res_bit (res_w[i]),
            .carry_o (chain[i+1])
        );
    end

    bsalu_flags #(.WIDTH(WIDTH)) u_flags (
        .word  (res_w),
        .flags (flags_d)
    );

    if (REG_FLAGS) begin : g_flag_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags_q <= '0;
            else        flags_q <= flags_d;
        end
    end else begin : g_flag_comb
        always_comb flags_q = flags_d;
    end

    always_comb begin
        result    = res_w;
        carry_out = chain[WIDTH] & (alu_op_e'(fn_sel) == OP_SUM);
        flag_neg  = flags_q.neg;
        flag_zero = flags_q.zero;
    end
endmodule

// File: rtl/bsalu_checker.sv
module bsalu_checker #(
    parameter int WIDTH     = 8,
    parameter bit REG_FLAGS = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [1:0]       fn_sel,
    input logic             en_a,
    input logic             en_b,
    input logic             inv_a,
    input logic [WIDTH-1:0] result,
    input logic             carry_out,
    input logic             flag_neg,
    input logic             flag_zero
);
    a_r4_carry_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_sel != 2'b11) |-> !carry_out);

    a_r2_notb: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_sel == 2'b10) |-> (result == ~(op_b & {WIDTH{en_b}})));

    a_r1_and_plain: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_sel == 2'b00 && en_a && en_b && !inv_a) |-> (result == (op_a & op_b)));

    a_r6_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_sel == 2'b01 && !en_a && inv_a) |-> (result == {WIDTH{1'b1}}));

    if (REG_FLAGS) begin : g_reg
        a_r9_neg_delay: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (flag_neg == $past(result[WIDTH-1])));
        a_r9_zero_delay: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (flag_zero == ($past(result) == '0)));
    end else begin : g_comb
        a_r10_neg_now: assert property (@(posedge clk) disable iff (!rst_n)
            flag_neg == result[WIDTH-1]);
        a_r10_zero_now: assert property (@(posedge clk) disable iff (!rst_n)
            flag_zero == (result == '0));
    end
endmodule

bind bsalu_top bsalu_checker #(.WIDTH(WIDTH), .REG_FLAGS(REG_FLAGS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_a      (op_a),
    .op_b      (op_b),
    .fn_sel    (fn_sel),
    .en_a      (en_a),
    .en_b      (en_b),
    .inv_a     (inv_a),
    .result    (result),
    .carry_out (carry_out),
    .flag_neg  (flag_neg),
    .flag_zero (flag_zero)
);

// File: tb/bsalu_top_tb_top.sv
`timescale 1ns/1ps
module bsalu_top_tb_top;
    localparam int W4 = 4;
    localparam int W8 = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [W4-1:0] a4 = '0, b4 = '0, r4;
    logic [1:0]    f4 = '0;
    logic ea4 = 1'b0, eb4 = 1'b0, ia4 = 1'b0, ci4 = 1'b0;
    logic co4, n4, z4;

    logic [W8-1:0] a8 = '0, b8 = '0, r8;
    logic [1:0]    f8 = '0;
    logic ea8 = 1'b0, eb8 = 1'b0, ia8 = 1'b0, ci8 = 1'b0;
    logic co8, n8, z8;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bsalu_top #(.WIDTH(W4), .REG_FLAGS(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_a(a4), .op_b(b4), .fn_sel(f4),
        .en_a(ea4), .en_b(eb4), .inv_a(ia4), .carry_in(ci4),
        .result(r4), .carry_out(co4), .flag_neg(n4), .flag_zero(z4));

    bsalu_top #(.WIDTH(W8), .REG_FLAGS(1'b0)) dut8_i (
        .clk(clk), .rst_n(rst_n), .op_a(a8), .op_b(b8), .fn_sel(f8),
        .en_a(ea8), .en_b(eb8), .inv_a(ia8), .carry_in(ci8),
        .result(r8), .carry_out(co8), .flag_neg(n8), .flag_zero(z8));

    task automatic check(input string tag, input int act, input int exp);
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference: result in low bits, carry in bit w
    function automatic int ref_alu(int w, int a, int b, int f,
                                   bit ea, bit eb, bit ia, bit ci);
        int mask = (1 << w) - 1;
        int ae = ea ? a : 0;
        int be = eb ? b : 0;
        int s;
        if (ia) ae = ~ae & mask;
        case (f)
            0: return ae & be;
            1: return ae | be;
            2: return ~be & mask;
            default: begin
                s = ae + be + int'(ci);
                return s;
            end
        endcase
    endfunction

    task automatic dir8(input string tag, input int a, input int b, input int f,
                        input bit ea, input bit eb, input bit ia, input bit ci,
                        input int exp_res, input int exp_c);
        int rv;
        @(negedge clk);
        a8 = W8'(a); b8 = W8'(b); f8 = 2'(f);
        ea8 = ea; eb8 = eb; ia8 = ia; ci8 = ci;
        #1;
        n_vec++;
        rv = ref_alu(W8, a, b, f, ea, eb, ia, ci);
        check({tag, " model"}, rv & 8'hFF, exp_res);
        check({tag, " result"}, int'(r8), exp_res);
        check({tag, " carry"}, int'(co8), exp_c);
        check("R10 neg now", int'(n8), (exp_res >> 7) & 1);
        check("R10 zero now", int'(z8), int'(exp_res == 0));
    endtask

    initial begin
        #(10 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int exp, exp_r, exp_c;
        // R9: flags held at zero while reset is low
        a4 = 4'h8; f4 = 2'b10; eb4 = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset neg", int'(n4), 0);
        check("R9 reset zero", int'(z4), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int f = 0; f < 4; f++)
        for (int ctl = 0; ctl < 16; ctl++)
        for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
            @(negedge clk);
            a4 = W4'(a); b4 = W4'(b); f4 = 2'(f);
            ea4 = ctl[0]; eb4 = ctl[1]; ia4 = ctl[2]; ci4 = ctl[3];
            #1;
            n_vec++;
            exp = ref_alu(W4, a, b, f, ctl[0], ctl[1], ctl[2], ctl[3]);
            exp_r = exp & 4'hF;
            exp_c = (f == 3) ? ((exp >> W4) & 1) : 0;
            case (f)
                0, 1: check("R1 logic result", int'(r4), exp_r);
                2:    check("R2 notb result", int'(r4), exp_r);
                default: check("R3 sum result", int'(r4), exp_r);
            endcase
            if (f == 3) check("R3 carry_out", int'(co4), exp_c);
            else        check("R4 carry idle", int'(co4), 0);
            if (ctl[2] == 1'b0 && f == 1 && ctl[1] == 1'b0)
                check("R5 pass A", int'(r4), ctl[0] ? a : 0);
            @(posedge clk);
            #1;
            check("R7 R9 neg reg", int'(n4), (exp_r >> (W4-1)) & 1);
            check("R8 R9 zero reg", int'(z4), int'(exp_r == 0));
        end

        dir8("R5 pass A",   8'hA5, 8'h3C, 1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, 0);
        dir8("R5 pass B",   8'hA5, 8'h3C, 1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 0);
        dir8("R6 not A",    8'hA5, 8'h3C, 1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h5A, 0);
        dir8("R6 all ones", 8'h12, 8'h00, 1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 0);
        dir8("R3 inc A",    8'h7F, 8'hFF, 3, 1'b1, 1'b0, 1'b0, 1'b1, 8'h80, 0);
        dir8("R3 wrap",     8'hFF, 8'h01, 3, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1);
        dir8("R2 notb",     8'hFF, 8'h0F, 2, 1'b1, 1'b1, 1'b0, 1'b1, 8'hF0, 0);
        dir8("R1 and",      8'hF0, 8'h3C, 0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h30, 0);
        dir8("R4 or carry", 8'hFF, 8'hFF, 1, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule